// File: doc/BRIEF.md
# Repeated-Addition Multiplier Unit

This block multiplies two unsigned operands by adding the multiplicand into a product accumulator once for every count of the multiplier. The multiplier is loaded into a down-counter. The counter's zero flag tells the sequencer when to stop. A multiplier of zero therefore needs no additions at all.

The block has two parts. A four-state sequencer issues load, add and decrement strobes. A datapath holds the multiplicand register, the counting multiplier and a product accumulator twice the operand width. A requester presents both operands and raises the operands-available strobe while the unit is idle. The unit then loads and counts, and raises its completion flag. The flag and the product stay put until the requester acknowledges, and the unit then returns to idle.

Top module: `repAddMul`

## Requirements
- R1: While reset (active high, asynchronous) is asserted, and right after it is released, `done` is low and `product` is 0.
- R2: While idle with `opsValid` low, the unit stays idle: `done` stays low and `product` does not change.
- R3: A clock edge in idle with `opsValid` high captures `opA` and `opB` and clears the product register to 0. `product` reads 0 after that edge.
- R4: When `done` rises, `product` equals `opA * opB` as unsigned numbers, for the operands captured at load.
- R5: `done` is first seen high after exactly 2 + 2·B clock edges, counting the load edge as edge 1, where B is the captured multiplier.
- R6: A multiplier of 0 gives a product of 0, with `done` high after 2 edges and no additions.
- R7: While `done` is high and `prodAck` is low, `done` stays high and `product` holds its value.
- R8: An edge with `done` and `prodAck` both high returns the unit to idle, and `done` is low after that edge.
- R9: State codes are idle=00, test=01, add/decrement=11 and complete=10. Every transition changes at most one state bit, except test to complete.
- R10: The product register is 2·W bits wide, so 255×255 = 65025 is exact for W=8. An addition never happens while the count is zero.
- R11: `opsValid` has no effect outside idle. Toggling it during a computation leaves the result and the latency unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| opA | input | W | Multiplicand operand |
| opB | input | W | Multiplier operand (repeat count) |
| opsValid | input | 1 | Operands available; sampled only in idle |
| prodAck | input | 1 | Product accepted acknowledge |
| done | output | 1 | Multiplication complete |
| product | output | 2·W | Product result |

## Verification
A result appears a data-dependent number of edges after the load edge: the product clears one edge after load, and `done` follows after 2 + 2·B edges. The bench counts rising edges from the load edge and samples on falling edges. It compares that count with 2 + 2·B and the product with the bench's own multiply. The return to idle is due one edge after the acknowledge, and the bench checks `done` on the following falling edge.

// File: rtl/repAddMulPkg.sv
package repAddMulPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_TEST   = 2'b01,
    ST_ADDDEC = 2'b11,
    ST_DONE   = 2'b10
  } seqState_t;

  typedef struct packed {
    logic load;
    logic add;
    logic dec;
  } ctlStrobes_t;
endpackage

// File: rtl/repAddMulCtrl.sv
module repAddMulCtrl
  import repAddMulPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opsValid,
  input  logic        prodAck,
  input  logic        countZero,
  output ctlStrobes_t ctl,
  output logic        done
);
  seqState_t state, nextState;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (opsValid) nextState = ST_TEST;
      ST_TEST:   nextState = countZero ? ST_DONE : ST_ADDDEC;
      ST_ADDDEC: nextState = ST_TEST;
      ST_DONE:   if (prodAck) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.load = (state == ST_IDLE) && opsValid;
    ctl.add  = (state == ST_ADDDEC);
    ctl.dec  = (state == ST_ADDDEC);
  end

  assign done = (state == ST_DONE);

  // R9
  stateStep_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(state ^ $past(state)) <= 1) ||
    ($past(state) == ST_TEST && state == ST_DONE));

  // R8
  ackLeave_chk: assert property (@(posedge clk) disable iff (rst)
    (done && prodAck) |=> (!done));

  // R7
  doneHold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !prodAck) |=> done);
endmodule

// File: rtl/repAddMulData.sv
module repAddMulData
  import repAddMulPkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W
)(
  input  logic          clk,
  input  logic          rst,
  input  ctlStrobes_t   ctl,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  output logic          countZero,
  output logic [PW-1:0] product
);
  logic [W-1:0]  mcandReg;
  logic [W-1:0]  countReg;
  logic [PW-1:0] accReg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      mcandReg <= '0;
      countReg <= '0;
    end else if (ctl.load) begin
      mcandReg <= opA;
      countReg <= opB;
    end else if (ctl.dec) begin
      countReg <= countReg - 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           accReg <= '0;
    else if (ctl.load) accReg <= '0;
    else if (ctl.add)  accReg <= accReg + {{W{1'b0}}, mcandReg};
  end

  assign countZero = (countReg == '0);
  assign product   = accReg;

  // R3
  loadClear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (product == '0));

  // R10
  addNonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.add |-> !countZero);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.add |=> (product >= $past(product)));
endmodule

// File: rtl/repAddMul.sv
module repAddMul
  import repAddMulPkg::*;
#(
  parameter int W = 8,
  localparam int PW = 2 * W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic          opsValid,
  input  logic          prodAck,
  output logic          done,
  output logic [PW-1:0] product
);
  ctlStrobes_t ctl;
  logic        countZero;

  repAddMulCtrl u_ctrl (
    .clk(clk), .rst(rst), .opsValid(opsValid), .prodAck(prodAck),
    .countZero(countZero), .ctl(ctl), .done(done)
  );

  repAddMulData #(.W(W)) u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .opA(opA), .opB(opB),
    .countZero(countZero), .product(product)
  );

  // R7
  prodHold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !prodAck) |=> $stable(product));
endmodule

// File: tb/repAddMul_tb.sv
module repAddMul_tb;
  localparam int W = 8;
  localparam int PW = 2 * W;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] opA, opB;
  logic opsValid, prodAck;
  logic done;
  logic [PW-1:0] product;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  repAddMul #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .opsValid(opsValid),
    .prodAck(prodAck), .done(done), .product(product)
  );

  function automatic logic [PW-1:0] expProd(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] p = '0;
    for (int i = 0; i < b; i++) p = p + PW'(a);
    return p;
  endfunction

  function automatic int expLat(input logic [W-1:0] b);
    return 2 + 2 * int'(b);
  endfunction

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b,
                       input int ackDelay, input bit noise);
    int edges;
    logic [PW-1:0] held;
    @(negedge clk);
    opA = a; opB = b; opsValid = 1'b1;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    opsValid = 1'b0;
    opA = ~a; opB = ~b;
    check("R3 product cleared after load", product == '0, product, 0);
    while (!done && edges < 600) begin
      if (noise) opsValid = $urandom_range(0, 1);
      @(posedge clk);
      edges++;
      @(negedge clk);
    end
    opsValid = 1'b0;
    check("R5 latency", edges == expLat(b), edges, expLat(b));
    check("R4 product", product == expProd(a, b), product, expProd(a, b));
    if (b == 0) check("R6 zero multiplier", product == '0 && edges == 2, product, 0);
    if (noise) check("R11 opsValid ignored while busy", product == expProd(a, b), product, expProd(a, b));
    held = product;
    for (int i = 0; i < ackDelay; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R7 done held", done == 1'b1, done, 1);
      check("R7 product held", product == held, product, held);
    end
    prodAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    prodAck = 1'b0;
    check("R8 done falls after ack", done == 1'b0, done, 0);
  endtask

  initial begin
    #(5ns * 190000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [PW-1:0] idleProd;
    void'($urandom(32'd4242));
    rst = 1'b1; opA = '0; opB = '0; opsValid = 1'b0; prodAck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 done in reset", done == 1'b0, done, 0);
    check("R1 product in reset", product == '0, product, 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 done after reset", done == 1'b0, done, 0);

    // R2: idle holds with opsValid low even when operands change
    opA = 8'd99; opB = 8'd7;
    idleProd = product;
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 idle done low", done == 1'b0, done, 0);
      check("R2 idle product steady", product == idleProd, product, idleProd);
    end

    // Directed corners
    runOp(8'd0,   8'd0,   0, 1'b0);   // R6
    runOp(8'd200, 8'd0,   2, 1'b0);   // R6
    runOp(8'd255, 8'd255, 1, 1'b0);   // R10
    check("R10 full-scale product", product == 16'd65025, product, 65025);
    runOp(8'd1,   8'd1,   3, 1'b0);
    runOp(8'd255, 8'd1,   0, 1'b0);
    runOp(8'd0,   8'd255, 0, 1'b0);
    runOp(8'd13,  8'd9,   2, 1'b1);   // R11

    // R2 again after a finished operation
    idleProd = product;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R2 idle after op", done == 1'b0 && product == idleProd, product, idleProd);
    end

    // Random mix
    for (int k = 0; k < 30; k++) begin
      runOp(W'($urandom), W'($urandom_range(0, 40)), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule